// File: doc/BRIEF.md
# Dual Alarm Interrupt Controller

This block watches a running time-of-day value and compares it, every cycle, with two programmed alarm times. When the time becomes equal to an alarm, the block latches a sticky flag for that alarm. It also drives one shared interrupt pin, which is active low. The host clears both flags with a one-cycle strobe that marks the end of a status read.

A mode input chooses how alarm 0 reaches the pin. In level mode (`pulse_mode` = 0), each flag pulls `irq_n` low while both the flag and its enable are set. In pulse mode (`pulse_mode` = 1), an alarm 0 match does not set a flag. Instead it drives `irq_n` low for a fixed count of slow-oscillator ticks. Alarm 1 still sets its flag in pulse mode, but that flag never reaches the pin, so the host must poll it. The timekeeping counters, any per-field alarm masking, the serial bus and storage all sit outside this block.

There are two kinds of state machine. Each alarm has its own flag machine with the states FLAG_CLEAR and FLAG_SET:
- A set event moves it from FLAG_CLEAR to FLAG_SET.
- A clear strobe with no set event in the same cycle moves it from FLAG_SET back to FLAG_CLEAR.

The pulse machine has the states PULSE_IDLE and PULSE_LOW:
- An alarm 0 match in pulse mode moves it from PULSE_IDLE to PULSE_LOW and resets the tick count to zero.
- In PULSE_LOW, a new match restarts the count.
- In PULSE_LOW, the last counted tick, or leaving pulse mode, returns it to PULSE_IDLE.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: A match is the first cycle in which `cur_time` equals an alarm time after it was unequal, or the first cycle after reset. Equality that persists over later cycles produces no further match, even after the flag has been cleared.
- R2: In level mode, an alarm match sets that alarm's flag at the next clock edge whatever its enable. `irq_n` is 0 exactly when (`flag0` and `alm0_en`) or (`flag1` and `alm1_en`) holds, and 1 otherwise.
- R3: A one-cycle `stat_rd_done` clears both flags at the next clock edge. In level mode, `irq_n` then returns to 1.
- R4: If a match on an alarm and `stat_rd_done` fall in the same cycle, that alarm's flag is 1 after the edge. The other flag is cleared.
- R5: In pulse mode, `alm0_en` and `alm1_en` have no effect on `irq_n`, and an alarm 0 match does not set `flag0`.
- R6: In pulse mode, an alarm 0 match drives `irq_n` to 0 from the next edge. `irq_n` stays 0 until the edge that counts the PULSE_LEN-th `osc_tick` after the match cycle, and is 1 from that edge on. A tick in the match cycle itself is not counted. Clearing `pulse_mode` ends the pulse.
- R7: In pulse mode, an alarm 1 match still sets `flag1` and leaves `irq_n` at 1. `stat_rd_done` clears `flag1`.
- R8: An alarm 0 match during an active pulse restarts the tick count from zero.
- R9: Out of reset, both flags are 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_time | input | TIME_W | Current time-of-day value |
| alm0_time | input | TIME_W | Alarm 0 compare value |
| alm1_time | input | TIME_W | Alarm 1 compare value |
| alm0_en | input | 1 | Alarm 0 interrupt enable (level mode) |
| alm1_en | input | 1 | Alarm 1 interrupt enable (level mode) |
| pulse_mode | input | 1 | 1 selects pulse mode for alarm 0 |
| osc_tick | input | 1 | One-cycle tick from the slow oscillator |
| stat_rd_done | input | 1 | One-cycle strobe at the end of a status read |
| flag0 | output | 1 | Alarm 0 flag |
| flag1 | output | 1 | Alarm 1 flag |
| irq_n | output | 1 | Shared interrupt, active low |

## Verification
A new alarm match and the clearing read can land in the same cycle. This happens when the host reads status just as the time reaches an alarm. The bench provokes the collision by moving `cur_time` onto an alarm value in the same cycle that it raises `stat_rd_done`. It does this once for the alarm whose flag is already set and once for the other alarm. It then expects the matching flag to be 1 and the other flag to be 0. The second collision, a fresh alarm 0 match while a pulse is running, is judged by the pulse ending exactly PULSE_LEN ticks after the restart rather than after the first match.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_t;

    typedef enum logic {
        PULSE_IDLE = 1'b0,
        PULSE_LOW  = 1'b1
    } pulse_state_t;

    localparam int unsigned NUM_ALARMS = 2;
endpackage

// File: rtl/alarm_edge_det.sv
module alarm_edge_det #(
    parameter int unsigned TIME_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] cur_time,
    input  logic [TIME_W-1:0] alm_time,
    output logic              hit
);
    logic eq_now;
    logic eq_q;

    assign eq_now = (cur_time == alm_time);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eq_q <= 1'b0;
        else        eq_q <= eq_now;
    end

    // only the first cycle of equality counts as an alarm event
    assign hit = eq_now & ~eq_q;
endmodule

// File: rtl/alarm_flag_fsm.sv
module alarm_flag_fsm
    import alarm_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic flag
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    // set wins over a clear in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (set_evt) state_d = FLAG_SET;
            FLAG_SET:   if (clr_evt && !set_evt) state_d = FLAG_CLEAR;
            default:    state_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q == FLAG_SET);
    end
endmodule

// File: rtl/alarm_pulse_fsm.sv
module alarm_pulse_fsm
    import alarm_irq_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic start,
    input  logic osc_tick,
    output logic active
);
    localparam int unsigned CNT_W = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_LEN - 1);

    pulse_state_t     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PULSE_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PULSE_IDLE: begin
                if (arm && start) begin
                    state_d = PULSE_LOW;
                    cnt_d   = '0;
                end
            end
            PULSE_LOW: begin
                if (!arm) begin
                    state_d = PULSE_IDLE;
                end else if (start) begin
                    cnt_d = '0;
                end else if (osc_tick) begin
                    if (cnt_q == LAST) state_d = PULSE_IDLE;
                    else               cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = PULSE_IDLE;
        endcase
    end

    always_comb begin
        active = (state_q == PULSE_LOW);
    end
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
#(
    parameter int unsigned TIME_W    = 24,
    parameter int unsigned PULSE_LEN = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] cur_time,
    input  logic [TIME_W-1:0] alm0_time,
    input  logic [TIME_W-1:0] alm1_time,
    input  logic              alm0_en,
    input  logic              alm1_en,
    input  logic              pulse_mode,
    input  logic              osc_tick,
    input  logic              stat_rd_done,
    output logic              flag0,
    output logic              flag1,
    output logic              irq_n
);
    logic [TIME_W-1:0]     alm_time [NUM_ALARMS];
    logic [NUM_ALARMS-1:0] hit;
    logic [NUM_ALARMS-1:0] set_evt;
    logic [NUM_ALARMS-1:0] flag;
    logic [NUM_ALARMS-1:0] en;
    logic                  pulse_active;

    assign alm_time[0] = alm0_time;
    assign alm_time[1] = alm1_time;
    assign en          = {alm1_en, alm0_en};

    // alarm 0 feeds its flag only in level mode; alarm 1 always does
    assign set_evt[0] = hit[0] & ~pulse_mode;
    assign set_evt[1] = hit[1];

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
        alarm_edge_det #(.TIME_W(TIME_W)) u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .cur_time (cur_time),
            .alm_time (alm_time[a]),
            .hit      (hit[a])
        );

        alarm_flag_fsm u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (set_evt[a]),
            .clr_evt (stat_rd_done),
            .flag    (flag[a])
        );
    end

    alarm_pulse_fsm #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (pulse_mode),
        .start    (hit[0]),
        .osc_tick (osc_tick),
        .active   (pulse_active)
    );

    assign flag0 = flag[0];
    assign flag1 = flag[1];

    always_comb begin
        if (pulse_mode) irq_n = ~pulse_active;
        else            irq_n = ~|(flag & en);
    end
endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
module alarm_irq_ctrl_chk #(
    parameter int unsigned TIME_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TIME_W-1:0] cur_time,
    input logic [TIME_W-1:0] alm0_time,
    input logic [TIME_W-1:0] alm1_time,
    input logic              alm0_en,
    input logic              alm1_en,
    input logic              pulse_mode,
    input logic              stat_rd_done,
    input logic              flag0,
    input logic              flag1,
    input logic              irq_n
);
    logic eq0, eq1, eq0_q, eq1_q, new0, new1;

    assign eq0 = (cur_time == alm0_time);
    assign eq1 = (cur_time == alm1_time);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eq0_q <= 1'b0;
            eq1_q <= 1'b0;
        end else begin
            eq0_q <= eq0;
            eq1_q <= eq1;
        end
    end

    assign new0 = eq0 && !eq0_q;
    assign new1 = eq1 && !eq1_q;

    p_persist_no_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && eq0 && eq0_q && !flag0) |=> !flag0);

    p_level_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && ((flag0 && alm0_en) || (flag1 && alm1_en))) |-> !irq_n);

    p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_done && !new0 && !new1) |=> (!flag0 && !flag1));

    p_set_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && new0) |=> flag0);

    p_no_flag0_pulsed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && !flag0) |=> (!flag0 || !$past(pulse_mode)));

    p_pulse_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && new0) |=> (!irq_n || !pulse_mode));

    p_flag1_any_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        new1 |=> flag1);
endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk #(.TIME_W(TIME_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cur_time     (cur_time),
    .alm0_time    (alm0_time),
    .alm1_time    (alm1_time),
    .alm0_en      (alm0_en),
    .alm1_en      (alm1_en),
    .pulse_mode   (pulse_mode),
    .stat_rd_done (stat_rd_done),
    .flag0        (flag0),
    .flag1        (flag1),
    .irq_n        (irq_n)
);

// File: tb/alarm_irq_ctrl_test.sv
`timescale 1ns/1ps
module alarm_irq_ctrl_test;
    localparam int TW  = 24;
    localparam int LEN = 1024;
    localparam logic [TW-1:0] A0   = 24'd100;
    localparam logic [TW-1:0] A1   = 24'd200;
    localparam logic [TW-1:0] IDLE = 24'd0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] cur_time = IDLE;
    logic          alm0_en = 1'b0, alm1_en = 1'b0;
    logic          pulse_mode = 1'b0, osc_tick = 1'b0, stat_rd_done = 1'b0;
    logic          flag0, flag1, irq_n;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    alarm_irq_ctrl #(.TIME_W(TW), .PULSE_LEN(LEN)) uut (
        .clk(clk), .rst_n(rst_n), .cur_time(cur_time),
        .alm0_time(A0), .alm1_time(A1),
        .alm0_en(alm0_en), .alm1_en(alm1_en),
        .pulse_mode(pulse_mode), .osc_tick(osc_tick),
        .stat_rd_done(stat_rd_done),
        .flag0(flag0), .flag1(flag1), .irq_n(irq_n)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_read();
        stat_rd_done = 1'b1;
        step();
        stat_rd_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5 * 150000);
        n_bad++;
        n_vec++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int seen;
        step(); step(); step();
        chk("R9 flag0 in reset", flag0, 0);
        chk("R9 irq_n in reset", irq_n, 1);
        rst_n = 1'b1;
        step();
        chk("R9 flag0 after reset", flag0, 0);
        chk("R9 flag1 after reset", flag1, 0);
        chk("R9 irq_n after reset", irq_n, 1);

        // R2/R3 sweep: every enable pair against every alarm pattern
        for (int e = 0; e < 4; e++) begin
            for (int p = 1; p < 4; p++) begin
                alm0_en = e[0];
                alm1_en = e[1];
                if (p[0]) begin cur_time = A0; step(); end
                if (p[1]) begin cur_time = A1; step(); end
                cur_time = IDLE;
                step();
                chk("R2 flag0", flag0, p[0]);
                chk("R2 flag1", flag1, p[1]);
                chk("R2 irq_n", irq_n, ((p[0] & e[0]) | (p[1] & e[1])) ? 0 : 1);
                do_read();
                chk("R3 flag0 cleared", flag0, 0);
                chk("R3 flag1 cleared", flag1, 0);
                chk("R3 irq_n released", irq_n, 1);
            end
        end

        // R1: persistent equality after a clear does not set again
        alm0_en = 1'b1; alm1_en = 1'b1;
        cur_time = A0;
        step();
        chk("R1 first match sets", flag0, 1);
        do_read();
        chk("R1 cleared while equal", flag0, 0);
        for (int i = 0; i < 5; i++) step();
        chk("R1 no re-set while equal", flag0, 0);
        chk("R1 irq_n stays released", irq_n, 1);
        cur_time = IDLE;
        step();

        // R4: set and clear collide, same alarm
        cur_time = A0; step();
        cur_time = IDLE; step();
        cur_time = A0; stat_rd_done = 1'b1;
        step();
        stat_rd_done = 1'b0;
        chk("R4 same-alarm set wins", flag0, 1);
        cur_time = IDLE; step();
        do_read();
        // R4: flag0 set, then alarm 1 match together with read
        cur_time = A0; step();
        cur_time = A1; stat_rd_done = 1'b1;
        step();
        stat_rd_done = 1'b0;
        chk("R4 new flag1 survives read", flag1, 1);
        chk("R4 old flag0 cleared", flag0, 0);
        cur_time = IDLE; step();
        do_read();

        // R5/R6: pulse mode, full pulse with tick every other cycle
        pulse_mode = 1'b1;
        step();
        cur_time = A0; osc_tick = 1'b1;
        step();
        cur_time = IDLE; osc_tick = 1'b0;
        chk("R6 pulse starts", irq_n, 0);
        chk("R5 flag0 unused in pulse mode", flag0, 0);
        alm0_en = 1'b0; alm1_en = 1'b0;
        step();
        chk("R5 enables ignored during pulse", irq_n, 0);
        alm0_en = 1'b1; alm1_en = 1'b1;
        seen = 0;
        while (seen < LEN) begin
            osc_tick = 1'b1; step(); osc_tick = 1'b0;
            seen++;
            chk("R6 pulse length", irq_n, (seen >= LEN) ? 1 : 0);
            step();
        end
        chk("R5 flag0 still clear", flag0, 0);

        // R8: restart during pulse
        cur_time = A0; step(); cur_time = IDLE;
        for (int i = 0; i < 500; i++) begin
            osc_tick = 1'b1; step(); osc_tick = 1'b0;
        end
        chk("R8 pulse still active mid-way", irq_n, 0);
        cur_time = A0; osc_tick = 1'b1;
        step();
        cur_time = IDLE; osc_tick = 1'b0;
        seen = 0;
        while (seen < LEN) begin
            osc_tick = 1'b1; step(); osc_tick = 1'b0;
            seen++;
            if (seen >= LEN - 2)
                chk("R8 restarted pulse length", irq_n, (seen >= LEN) ? 1 : 0);
        end

        // R6: leaving pulse mode ends a pulse
        cur_time = A0; step(); cur_time = IDLE;
        chk("R6 second pulse starts", irq_n, 0);
        pulse_mode = 1'b0; step();
        chk("R6 mode exit releases", irq_n, 1);
        pulse_mode = 1'b1; step();
        chk("R6 no pulse resumes", irq_n, 1);

        // R7: alarm 1 in pulse mode
        cur_time = A1; step(); cur_time = IDLE;
        chk("R7 flag1 set in pulse mode", flag1, 1);
        chk("R7 irq_n untouched", irq_n, 1);
        step();
        do_read();
        chk("R7 flag1 cleared by read", flag1, 0);
        pulse_mode = 1'b0;
        step();
        chk("R9 idle after sequence", irq_n, 1);

        finish_run();
    end
endmodule